// File: doc/BRIEF.md
# Multi-rate status flag encoder

This block turns a set of charger condition flags into one active-low status line. A single pin carries the condition by how fast it blinks. When the supply feeding the charger is invalid, the line is released, and an external pull-up reads it as high. When the supply is valid and no condition is active, the line is pulled low and held there. Each active condition blinks the line at its own rate with a 50% duty cycle. The block drives a pull-low enable and a release indication for an open-drain pad outside the block.

When several conditions are active at once, only the fastest rate is shown. When that condition clears, the next-fastest active condition takes over. All half-period lengths are computed from a clock-frequency parameter. When the displayed condition changes, the blink counter restarts, so the new rate begins with a complete half-period.

Top module: `stflag_encoder`

## Requirements
- R1: While `supply_ok` is 0, `release_o` is 1 and `pull_low_o` is 0, whatever `event_i` holds. The same values are present during reset.
- R2: While `supply_ok` is 1 and `event_i` is all zero, `pull_low_o` is held at 1 and `release_o` at 0.
- R3: `event_i` bit 0 (end of charge) alone blinks `pull_low_o` with both half-periods equal to floor(CLK_HZ*10/82) clock cycles (4.1 Hz).
- R4: Bit 1 (charging, pre-charge or fast) alone gives half-periods of floor(CLK_HZ*10/124) cycles (6.2 Hz).
- R5: Bit 2 (overcharge fault) alone gives half-periods of floor(CLK_HZ*10/164) cycles (8.2 Hz).
- R6: Bit 3 (charge timeout) alone gives half-periods of floor(CLK_HZ*10/204) cycles (10.2 Hz).
- R7: Bit 4 (battery below pre-charge level after fast charge began) alone gives half-periods of floor(CLK_HZ*10/256) cycles (12.8 Hz).
- R8: Bit 5 (die thermal warning) alone gives half-periods of floor(CLK_HZ*10/284) cycles (14.2 Hz).
- R9: Bit 6 (battery temperature fault) alone gives half-periods of floor(CLK_HZ*10/324) cycles (16.2 Hz).
- R10: When several bits are set, the highest-numbered (fastest) set bit alone sets the rate. When it clears, the rate of the next highest set bit follows.
- R11: A change of the displayed condition reaches the outputs three clock edges after the inputs change. It starts a pull-low phase that lasts one full half-period of the new rate.
- R12: `pull_low_o` and `release_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Input supply within its valid window |
| event_i | input | 7 | Condition flags; bit n has priority over all lower bits |
| pull_low_o | output | 1 | 1 = pad drives the flag low |
| release_o | output | 1 | 1 = pad is high impedance (supply invalid) |

## Verification
The bench measures both half-periods for each condition on its own. An off-by-one reload or a wrong rate entry shows up there as a cycle count that is one too many or the rate of a different condition. The bench overlaps the fastest and the slowest conditions, then removes the fast one. A reversed priority would show the slow rate first, and a selection that sticks would fail to fall back to end-of-charge. It also switches from one blinking condition to another in the middle of a half-period. A counter that is not restarted would give a shortened first pull-low phase. Invalid supply with every fault set checks that release wins over all blink codes.

// File: rtl/stflag_pkg.sv
package stflag_pkg;

  localparam int NUM_EVT = 7;
  localparam int IDX_W   = $clog2(NUM_EVT);

  // valid=0: released; valid=1, blink=0: steady low; blink=1: rate idx
  typedef struct packed {
    logic             valid;
    logic             blink;
    logic [IDX_W-1:0] idx;
  } flag_sel_t;

  // blink rate in tenths of a hertz, index = priority (higher is faster)
  function automatic int unsigned rate_dhz(input int unsigned idx);
    case (idx)
      0:       return 41;
      1:       return 62;
      2:       return 82;
      3:       return 102;
      4:       return 128;
      5:       return 142;
      default: return 162;
    endcase
  endfunction

  function automatic longint unsigned half_cycles(input longint unsigned clk_hz,
                                                  input int unsigned idx);
    longint unsigned h;
    h = (clk_hz * 10) / (2 * longint'(rate_dhz(idx)));
    if (h == 0) h = 1;
    return h;
  endfunction

endpackage

// File: rtl/stflag_prio_sel.sv
module stflag_prio_sel
  import stflag_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               supply_ok,
  input  logic [NUM_EVT-1:0] event_i,
  output flag_sel_t          sel_q
);

  flag_sel_t sel_d;

  always_comb begin
    sel_d       = '0;
    sel_d.valid = supply_ok;
    if (supply_ok) begin
      for (int i = 0; i < NUM_EVT; i++) begin
        if (event_i[i]) begin
          sel_d.blink = 1'b1;
          sel_d.idx   = IDX_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= sel_d;
  end

  assert_invalid_sel_R1: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!sel_q.valid && !sel_q.blink));

  assert_top_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && event_i[NUM_EVT-1]) |=> (sel_q.blink && sel_q.idx == IDX_W'(NUM_EVT-1)));

  assert_quiet_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (supply_ok && event_i == '0) |=> (sel_q.valid && !sel_q.blink));

endmodule

// File: rtl/stflag_blink.sv
module stflag_blink
  import stflag_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 250_000_000
) (
  input  logic      clk,
  input  logic      rst,
  input  flag_sel_t sel,
  output flag_sel_t cur_q,
  output logic      phase_q
);

  localparam longint unsigned MAX_HALF = half_cycles(CLK_HZ, 0);
  localparam int CNT_W = (MAX_HALF < 2) ? 1 : $clog2(MAX_HALF);

  logic [CNT_W-1:0] reload_tab [NUM_EVT];
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_rate
    localparam longint unsigned HALF = half_cycles(CLK_HZ, g);
    assign reload_tab[g] = CNT_W'(HALF - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q   <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (sel != cur_q) begin
      cur_q   <= sel;
      cnt_q   <= reload_tab[sel.idx];
      phase_q <= 1'b1;
    end else if (cur_q.blink) begin
      if (cnt_q == '0) begin
        phase_q <= ~phase_q;
        cnt_q   <= reload_tab[cur_q.idx];
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cur_q.blink |-> (cnt_q <= reload_tab[cur_q.idx]));

  assert_toggle_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (cur_q.blink && cnt_q == '0 && sel == cur_q) |=> (phase_q != $past(phase_q)));

  assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
    (sel != cur_q && sel.blink) |=> phase_q);

endmodule

// File: rtl/stflag_encoder.sv
module stflag_encoder
  import stflag_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 250_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               supply_ok,
  input  logic [NUM_EVT-1:0] event_i,
  output logic               pull_low_o,
  output logic               release_o
);

  flag_sel_t sel_q;
  flag_sel_t cur_q;
  logic      phase_q;

  stflag_prio_sel u_sel (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .event_i   (event_i),
    .sel_q     (sel_q)
  );

  stflag_blink #(.CLK_HZ(CLK_HZ)) u_blink (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel_q),
    .cur_q   (cur_q),
    .phase_q (phase_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_low_o <= 1'b0;
      release_o  <= 1'b1;
    end else begin
      pull_low_o <= cur_q.valid & (~cur_q.blink | phase_q);
      release_o  <= ~cur_q.valid;
    end
  end

  assert_pad_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(pull_low_o && release_o));

  assert_release_R1: assert property (@(posedge clk) disable iff (rst)
    !cur_q.valid |=> (release_o && !pull_low_o));

  assert_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (cur_q.valid && !cur_q.blink) |=> pull_low_o);

endmodule

// File: tb/stflag_encoder_bench.sv
module stflag_encoder_bench;

  localparam longint unsigned CLK_HZ = 10000;

  logic       clk = 1'b0;
  logic       rst;
  logic       supply_ok;
  logic [6:0] event_i;
  logic       pull_low_o;
  logic       release_o;
  int         n_chk  = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  stflag_encoder #(.CLK_HZ(CLK_HZ)) u_stflag_encoder (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .event_i(event_i),
    .pull_low_o(pull_low_o), .release_o(release_o)
  );

  function automatic int bench_rate(input int i);
    int t [7] = '{41, 62, 82, 102, 128, 142, 162};
    return t[i];
  endfunction

  function automatic int exp_half(input int i);
    return int'((CLK_HZ * 10) / (2 * bench_rate(i)));
  endfunction

  function automatic int top_idx(input logic [6:0] ev);
    int r = -1;
    for (int i = 0; i < 7; i++) if (ev[i]) r = i;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [6:0] ev);
    @(negedge clk);
    supply_ok = v;
    event_i   = ev;
  endtask

  // from the drive negedge, the third negedge follows the output edge
  task automatic first_low(input int i, input string tag);
    int n = 0;
    repeat (3) @(negedge clk);
    while (pull_low_o && n < 100000) begin n++; @(negedge clk); end
    check(n == exp_half(i), tag, n, exp_half(i));
  endtask

  task automatic measure(input int i, input string tag);
    int h = exp_half(i);
    int lim = 4 * h + 20;
    int n = 0;
    int lo = 0;
    int hi = 0;
    while (pull_low_o && n < lim) begin @(negedge clk); n++; end
    n = 0;
    while (!pull_low_o && n < lim) begin @(negedge clk); n++; end
    while (pull_low_o && lo < lim) begin lo++; @(negedge clk); end
    while (!pull_low_o && hi < lim) begin hi++; @(negedge clk); end
    check(lo == h, tag, lo, h);
    check(hi == h, tag, hi, h);
  endtask

  task automatic hold_check(input logic pl, input logic rel, input int cyc, input string tag);
    int bad = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (pull_low_o !== pl || release_o !== rel) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    string tags [7] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R9"};
    void'($urandom(32'd7321));
    rst = 1'b1; supply_ok = 1'b0; event_i = '0;
    repeat (5) @(negedge clk);
    // R1 during reset
    check(release_o === 1'b1 && pull_low_o === 1'b0, "R1", {release_o, pull_low_o}, 2'b10);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    hold_check(1'b0, 1'b1, 50, "R1");

    // R2 steady low with a valid supply
    drive(1'b1, '0);
    repeat (3) @(negedge clk);
    hold_check(1'b1, 1'b0, 500, "R2");

    // each condition on its own (R3..R9), with restart from steady (R11)
    for (int i = 0; i < 7; i++) begin
      drive(1'b1, '0);
      repeat (6) @(negedge clk);
      drive(1'b1, 7'(1 << i));
      first_low(i, tags[i]);
      measure(i, tags[i]);
    end

    // R10 fastest and slowest together, then the fast one clears
    drive(1'b1, '0);
    repeat (6) @(negedge clk);
    drive(1'b1, 7'b1000001);
    first_low(6, "R10");
    measure(6, "R10");
    drive(1'b1, 7'b0000001);
    first_low(0, "R10");
    measure(0, "R10");

    // R11 switch between blink codes in the middle of a half-period
    drive(1'b1, 7'b0000010);
    repeat (3 + exp_half(1) + 100) @(negedge clk);
    drive(1'b1, 7'b0010010);
    first_low(4, "R11");
    measure(4, "R11");

    // R1 invalid supply overrides every fault
    drive(1'b0, 7'h7f);
    repeat (3) @(negedge clk);
    hold_check(1'b0, 1'b1, 300, "R1");

    // random mixes, R10 priority checked by bench function
    for (int k = 0; k < 10; k++) begin
      logic       v;
      logic [6:0] ev;
      v  = ($urandom % 6) != 0;
      ev = 7'($urandom) & 7'($urandom);
      drive(v, ev);
      repeat (3) @(negedge clk);
      if (!v)             hold_check(1'b0, 1'b1, 100, "R1");
      else if (ev == '0)  hold_check(1'b1, 1'b0, 100, "R2");
      else                measure(top_idx(ev), "R10");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule